// File: doc/BRIEF.md
# Busy-Indicator Serial ADC Read Controller

This block runs the host side of a single 16-bit successive-approximation converter. The converter is wired as a three-wire device: its serial data input is tied high, the convert line also acts as the chip select, and its serial data output has a pull-up. When the block gets a start request, it drives the convert line high for a short, fixed pulse and then holds it low. While the conversion runs, the data line floats and reads high through the pull-up. When the converter finishes, it pulls the line low. The block sees this falling edge through a two-stage synchroniser, produces a divided serial clock, shifts in the 16-bit result most significant bit first, and presents the word on a parallel bus with a one-cycle valid strobe.

If the converter never signals completion, a timeout counter raises a one-cycle fault pulse and sends the controller back to idle. This happens without a single serial clock edge. After a successful read, the block accepts no new start until a minimum sample period has passed, counted from the previous start. That period is at least the convert pulse plus the longest conversion time, so the low phase that the converter needs is always respected.

States: `S_IDLE` (waits for a start), `S_PULSE` (convert line high), `S_WAIT` (convert low, watches for the data-ready fall, counts the timeout), `S_SHIFT` (serial clock runs), `S_DONE` (valid strobe), `S_FAULT` (timeout strobe) and `S_REST` (waits out the sample period). Transitions:
- `S_IDLE`→`S_PULSE` on start.
- `S_PULSE`→`S_WAIT` when the pulse width has elapsed.
- `S_WAIT`→`S_SHIFT` on the synchronised falling edge.
- `S_WAIT`→`S_FAULT` when the timeout expires.
- `S_SHIFT`→`S_DONE` on the 17th falling clock edge.
- `S_DONE`→`S_REST`.
- `S_FAULT`→`S_IDLE`.
- `S_REST`→`S_PULSE` when the period has elapsed and start is high.
- `S_REST`→`S_IDLE` when the period has elapsed and start is low.

Top module: `sar_busy_reader`

## Requirements
- R1: While reset is asserted and just after it is released, `cnv_o`, `sck_o`, `valid_o` and `timeout_o` are all low.
- R2: A start accepted in idle drives `cnv_o` high for exactly `CNV_HIGH_CYC` clock cycles, after which it returns low.
- R3: A start request that arrives while a conversion or read is in progress is ignored: it produces no extra rising edge on `cnv_o`.
- R4: `sck_o` idles low and makes no edge until a high-to-low transition of `sdo_i` has been seen after the convert pulse.
- R5: Each read makes exactly 17 falling edges on `sck_o`. Consecutive falling edges are `2*SCK_HALF` clock cycles apart.
- R6: The converter puts bit 15 out after falling edge 1 and bit 0 after falling edge 16. The controller samples on falling edges 2 to 17, so `data_o` equals the converter's word, most significant bit first.
- R7: After the 17th falling edge, `valid_o` is high for exactly one cycle. `data_o` holds the captured word from that cycle until the next read.
- R8: If no data-ready fall arrives within `TIMEOUT_CYC` cycles of the convert pulse ending, `timeout_o` is high for one cycle. This is cycle `CNV_HIGH_CYC+TIMEOUT_CYC`, counting the first cycle of `cnv_o` high as cycle 0. No `valid_o` follows, and a later start is accepted normally.
- R9: Accepted starts are spaced at least `max(CYCLE_MIN, CNV_HIGH_CYC+CONV_MAX_CYC)` cycles apart. If `start_i` is held high and the read ends earlier, the spacing is exactly that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a sample |
| cnv_o | output | 1 | Convert / select line to the converter |
| sck_o | output | 1 | Divided serial clock |
| sdo_i | input | 1 | Converter serial data, pulled up when released |
| data_o | output | DATA_W | Last captured result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| timeout_o | output | 1 | One-cycle strobe marking a missing data-ready |

## Verification
The hardest situations to reach are a start that arrives in the middle of a transaction and the exact spacing of back-to-back samples. Both depend on where the controller is in its state sequence when the request lands. The stimulus pulses start while the controller waits for data-ready and again while the clock is running, and later holds start high across two full reads. A behavioural converter in the bench drives the data line on each clock fall. It can also be muted, so the timeout path is reached without ever releasing the busy level.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PULSE,
        S_WAIT,
        S_SHIFT,
        S_DONE,
        S_FAULT,
        S_REST
    } sbr_state_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{INIT}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sbr_clkdiv.sv
module sbr_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (!run_i)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_busy_reader.sv
module sar_busy_reader
    import sbr_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int CNV_HIGH_CYC = 4,
    parameter int CONV_MAX_CYC = 40,
    parameter int TIMEOUT_CYC  = 100,
    parameter int SCK_HALF     = 2,
    parameter int CYCLE_MIN    = 150
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              cnv_o,
    output logic              sck_o,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              timeout_o
);
    localparam int HOLD   = CNV_HIGH_CYC + CONV_MAX_CYC;
    localparam int GAP    = (CYCLE_MIN > HOLD) ? CYCLE_MIN : HOLD;
    localparam int TMR_MX = (TIMEOUT_CYC > CNV_HIGH_CYC) ? TIMEOUT_CYC : CNV_HIGH_CYC;
    localparam int TMR_W  = $clog2(TMR_MX + 1);
    localparam int GAP_W  = $clog2(GAP + 1);
    localparam int FALLS  = DATA_W + 1;
    localparam int FC_W   = $clog2(FALLS + 1);

    sbr_state_e        state_q, state_d;
    logic [TMR_W-1:0]  tmr_q;
    logic [GAP_W-1:0]  cyc_q;
    logic [FC_W-1:0]   fall_q;
    logic [DATA_W-1:0] shreg_q;
    logic              sck_q, sdo_s, sdo_prev_q, tick;
    logic              busy_fall, gap_done, fall_edge;

    sbr_sync #(.STAGES(2), .INIT(1'b1)) sync_i (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sdo_i), .q_o(sdo_s)
    );

    sbr_clkdiv #(.HALF(SCK_HALF)) div_i (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .run_i (state_q == S_SHIFT), .tick_o(tick)
    );

    assign busy_fall = sdo_prev_q && !sdo_s;
    assign gap_done  = (cyc_q >= GAP_W'(GAP - 1));
    assign fall_edge = tick && sck_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_PULSE;
            S_PULSE: if (tmr_q == TMR_W'(CNV_HIGH_CYC - 1)) state_d = S_WAIT;
            S_WAIT: begin
                if (busy_fall)                              state_d = S_SHIFT;
                else if (tmr_q == TMR_W'(TIMEOUT_CYC - 1))  state_d = S_FAULT;
            end
            S_SHIFT: if (fall_edge && fall_q == FC_W'(FALLS - 1)) state_d = S_DONE;
            S_DONE:  state_d = S_REST;
            S_FAULT: state_d = S_IDLE;
            S_REST:  if (gap_done) state_d = start_i ? S_PULSE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and datapath counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= S_IDLE;
            tmr_q      <= '0;
            cyc_q      <= '0;
            fall_q     <= '0;
            shreg_q    <= '0;
            sck_q      <= 1'b0;
            sdo_prev_q <= 1'b1;
        end else begin
            state_q    <= state_d;
            sdo_prev_q <= sdo_s;

            if (state_d != state_q)              tmr_q <= '0;
            else if (tmr_q != TMR_W'(TMR_MX))    tmr_q <= tmr_q + 1'b1;

            if (state_d == S_PULSE && state_q != S_PULSE) cyc_q <= '0;
            else if (state_q != S_IDLE && !gap_done)      cyc_q <= cyc_q + 1'b1;

            if (state_q != S_SHIFT) begin
                sck_q  <= 1'b0;
                fall_q <= '0;
            end else if (tick) begin
                sck_q <= !sck_q;
                if (sck_q) begin
                    fall_q <= fall_q + 1'b1;
                    if (fall_q != '0) shreg_q <= {shreg_q[DATA_W-2:0], sdo_s};
                end
            end
        end
    end

    // outputs
    always_comb begin
        cnv_o     = (state_q == S_PULSE);
        sck_o     = sck_q;
        valid_o   = (state_q == S_DONE);
        timeout_o = (state_q == S_FAULT);
        data_o    = shreg_q;
    end

    // R2
    cnv_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnv_o |-> (tmr_q < TMR_W'(CNV_HIGH_CYC)));

    // R3
    cnv_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_PULSE && $past(state_q) != S_PULSE)
            |-> ($past(state_q) == S_IDLE || $past(state_q) == S_REST));

    // R4
    sck_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != S_SHIFT && $past(state_q) != S_SHIFT) |-> !sck_o);

    // R5
    fall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_q <= FC_W'(FALLS));

    // R7
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> (!valid_o && $stable(data_o)));

    // R8
    timeout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> (!timeout_o && !cnv_o && !valid_o));
endmodule

// File: tb/sar_busy_reader_tb_top.sv
module sar_busy_reader_tb_top;
    localparam int CNV_HIGH = 4;
    localparam int TIMEOUT  = 100;
    localparam int HALF     = 2;
    localparam int GAP      = 150;
    localparam int NVEC     = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0000, 8'd10}, {16'hFFFF, 8'd12}, {16'h8000, 8'd20}, {16'h0001, 8'd35},
        {16'hA5C3, 8'd8},  {16'h7FFE, 8'd15}, {16'h1234, 8'd27}, {16'h5A5A, 8'd9}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdo = 1'b1;
    logic cnv, sck, valid, tmo;
    logic [15:0] data;

    int n_chk = 0, n_bad = 0;
    logic [15:0] mdl_word = '0;
    int  mdl_delay = 10;
    bit  mdl_mute = 0, armed = 0;
    int  fall_n = 0, early = 0, period_bad = 0, t_cyc = 0, last_fall = 0;
    int  nc = 0, run = 0, last_width = 0, rises = 0, t_rise = 0, t_prev_rise = 0;
    int  valids = 0, t_tmo = -1;
    logic cnv_prev = 1'b0;

    always #2 clk = ~clk;

    sar_busy_reader dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cnv_o(cnv), .sck_o(sck),
        .sdo_i(sdo), .data_o(data), .valid_o(valid), .timeout_o(tmo)
    );

    // converter model
    always @(posedge clk) t_cyc++;
    initial begin
        forever begin
            @(posedge cnv);
            armed = 1; sdo = 1'b1; fall_n = 0;
            repeat (mdl_delay) @(posedge clk);
            if (!mdl_mute) begin sdo = 1'b0; armed = 0; end
        end
    end
    always @(posedge sck) if (armed) early++;
    always @(negedge sck) begin
        fall_n++;
        if (fall_n > 1 && (t_cyc - last_fall) != 2*HALF) period_bad++;
        last_fall = t_cyc;
        if (fall_n <= 16) sdo = mdl_word[16-fall_n];
        else              sdo = 1'b1;
    end

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        nc++;
        if (cnv) begin
            run++;
            if (!cnv_prev) begin rises++; t_prev_rise = t_rise; t_rise = nc; end
        end else if (cnv_prev) begin
            last_width = run; run = 0;
        end
        if (valid) valids++;
        if (tmo) t_tmo = nc;
        cnv_prev = cnv;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 0;
        for (int i = 0; i < 1000 && !seen; i++) begin
            @(negedge clk);
            if (valid) seen = 1;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit seen;
        int r0, v0, e0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!cnv && !sck && !valid && !tmo, "R1 in reset", {cnv, sck, valid, tmo}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cnv && !sck && !valid && !tmo, "R1 after reset", {cnv, sck, valid, tmo}, 0);

        // table of vectors
        for (int k = 0; k < NVEC; k++) begin
            mdl_word = VEC[k][23:8]; mdl_delay = int'(VEC[k][7:0]);
            e0 = early;
            pulse_start();
            wait_valid(seen);
            chk(seen && data == mdl_word, "R6 data word", data, mdl_word);
            chk(last_width == CNV_HIGH, "R2 cnv width", last_width, CNV_HIGH);
            chk(fall_n == 17, "R5 sck fall count", fall_n, 17);
            chk(early == e0, "R4 sck before busy fall", early - e0, 0);
            @(negedge clk);
            chk(!valid && data == mdl_word, "R7 one-cycle valid, data held", valid, 0);
            repeat (GAP) @(negedge clk);
        end
        chk(period_bad == 0, "R5 sck period", period_bad, 0);

        // R3: start ignored while busy
        mdl_word = 16'hC3A5; mdl_delay = 30; r0 = rises;
        pulse_start();
        repeat (12) @(negedge clk);
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        wait_valid(seen);
        chk(seen && data == 16'hC3A5, "R3 read intact", data, 16'hC3A5);
        repeat (GAP) @(negedge clk);
        chk(rises - r0 == 1, "R3 extra cnv rises", rises - r0, 1);

        // R9: held start gives exact spacing
        mdl_word = 16'h0F0F; mdl_delay = 10;
        @(negedge clk); start = 1'b1;
        wait_valid(seen);
        wait (rises >= 0);
        r0 = rises;
        while (rises == r0) @(negedge clk);
        start = 1'b0;
        chk(t_rise - t_prev_rise == GAP, "R9 start spacing", t_rise - t_prev_rise, GAP);
        wait_valid(seen);
        chk(seen && data == 16'h0F0F, "R9 second read", data, 16'h0F0F);
        repeat (GAP) @(negedge clk);

        // R8: timeout
        mdl_mute = 1; v0 = valids; e0 = early; t_tmo = -1;
        pulse_start();
        repeat (CNV_HIGH + TIMEOUT + 20) @(negedge clk);
        chk(t_tmo - t_rise == CNV_HIGH + TIMEOUT, "R8 timeout cycle", t_tmo - t_rise, CNV_HIGH + TIMEOUT);
        chk(valids == v0, "R8 no valid", valids - v0, 0);
        chk(early == e0, "R4 no sck on timeout", early - e0, 0);
        mdl_mute = 0; armed = 0; sdo = 1'b1;
        repeat (GAP) @(negedge clk);
        mdl_word = 16'h9001; mdl_delay = 14;
        pulse_start();
        wait_valid(seen);
        chk(seen && data == 16'h9001, "R8 recovery read", data, 16'h9001);

        finish_run();
    end
endmodule